// File: doc/BRIEF.md
# Auxiliary IO and System-Control Register Block

This block is a small memory-mapped peripheral holding the miscellaneous control registers of a workstation I/O chip. Software reaches it over a simple synchronous bus. The bus carries an address, a request, a write flag, a two-bit access-size code and 32-bit write data. Read data comes back registered one cycle after the request. The registers are a configuration byte, two scratch bytes (diagnostic and modem control), a 16-bit LED word, an auxiliary byte that fires a floppy terminal-count strobe, a power-down byte with power-fail status, a 32-bit system-control word that asks for a system reset, and a CPU-idle location that halts the processor when written.

The block watches a power-failing input and drives several outputs: a level interrupt, a one-cycle terminal-count pulse, a sticky power-off request, a one-cycle reset request and a one-cycle halt strobe. Reset has a selective effect. It clears the configuration, auxiliary, power-down and modem registers. The diagnostic, LED and system-control contents survive it, so firmware can leave a trail across a reset it asked for itself.

Register index is address bits [4:2]: configuration 0x00, diagnostic 0x04, modem 0x08, LED 0x0C, system control 0x10, auxiliary 0x14, power-down 0x18, idle 0x1C. Size codes: 0 byte, 1 halfword, 2 word, 3 illegal.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `irq_o` is high exactly when power-down bit 5 (status) and configuration bit 3 (enable) are both set; it follows a configuration write by one cycle.
- R2: On a cycle where `pwr_fail_i` differs from its value in the previous cycle, status bit 5 becomes 1 if the input is 1 and configuration bit 3 is set, and becomes 0 otherwise; without a change the input has no effect.
- R3: A power-down write takes only bits 0 and 1 from the bus; status bit 5 is kept unless bit 1 is written as 1, which clears it; bit 1 always reads 0.
- R4: A power-down write stores bit 0; writing it as 1 raises `pwroff_o`, which stays high until reset.
- R5: An auxiliary write with bit 1 set gives one `tc_pulse_o` cycle, in the cycle after the write; the other bits are stored and bit 1 reads 0.
- R6: A word write to 0x10 with bit 0 set gives one `rst_req_o` cycle and makes 0x10 read 0x00000002; a write without bit 0 changes nothing.
- R7: Reset clears configuration, auxiliary, power-down, modem and `pwroff_o`; diagnostic, LED and system-control values are kept.
- R8: The LED register needs size 1, system control needs size 2, and all others need size 0, always with address bits [1:0] zero; any other access is ignored and reads zero.
- R9: Any legal write to 0x1C gives one `halt_o` cycle; reads of 0x1C return zero.
- R10: `rdata_o` holds the addressed register one cycle after a read request and is zero in every other cycle.
- R11: Diagnostic and modem registers keep 8 written bits and the LED register keeps 16 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| req_i | input | 1 | bus access request |
| wr_i | input | 1 | 1 write, 0 read |
| addr_i | input | 5 | byte address |
| size_i | input | 2 | access size code |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | registered read data |
| pwr_fail_i | input | 1 | power-failing indication |
| irq_o | output | 1 | power-fail level interrupt |
| tc_pulse_o | output | 1 | floppy terminal-count pulse |
| pwroff_o | output | 1 | sticky power-off request |
| rst_req_o | output | 1 | system reset request pulse |
| halt_o | output | 1 | CPU halt pulse |

## Verification
A wrong status or enable bit shows on `irq_o` in the cycle after the write or input edge that disturbed it, and on `rdata_o` at the next read of the power-down register. Strobe outputs that are wrong show up in the very cycle after the write, as an extra or missing pulse. A reset that clears the wrong registers is exposed by reading every location back right after reset, since the kept registers hold known, non-zero patterns at that point.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned NUM_REGS = 1 << IDX_W;
  localparam int unsigned ADDR_W   = IDX_W + 2;
  localparam int unsigned LED_W    = 16;
  localparam int unsigned BYTE_W   = 8;

  typedef enum logic [IDX_W-1:0] {
    REG_CFG  = 3'd0,
    REG_DIAG = 3'd1,
    REG_MDM  = 3'd2,
    REG_LED  = 3'd3,
    REG_SYS  = 3'd4,
    REG_AUX1 = 3'd5,
    REG_PWR  = 3'd6,
    REG_IDLE = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  localparam int unsigned CFG_PF_EN_BIT = 3;
  localparam int unsigned PWR_OFF_BIT   = 0;
  localparam int unsigned PWR_CLR_BIT   = 1;
  localparam int unsigned PWR_FAIL_BIT  = 5;
  localparam int unsigned AUX1_TC_BIT   = 1;
  localparam int unsigned SYS_RST_BIT   = 0;
  localparam logic [BYTE_W-1:0] SYS_RST_STAT = 8'h02;

  function automatic logic [1:0] legal_size(logic [IDX_W-1:0] idx);
    case (idx)
      REG_LED: return SZ_HALF;
      REG_SYS: return SZ_WORD;
      default: return SZ_BYTE;
    endcase
  endfunction
endpackage

// File: rtl/aux_decode.sv
module aux_decode
  import aux_sysctl_pkg::*;
(
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic [NUM_REGS-1:0] wr_hit_o,
  output logic [NUM_REGS-1:0] rd_hit_o
);
  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    logic hit;
    assign hit = req_i && aligned && (addr_i[ADDR_W-1:2] == IDX_W'(i))
                 && (size_i == legal_size(IDX_W'(i)));
    assign wr_hit_o[i] = hit && wr_i;
    assign rd_hit_o[i] = hit && !wr_i;
  end
endmodule

// File: rtl/aux_pwr_unit.sv
module aux_pwr_unit
  import aux_sysctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_fail_i,
  input  logic              cfg_we_i,
  input  logic              pwr_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] cfg_o,
  output logic [BYTE_W-1:0] pwr_reg_o,
  output logic              irq_o,
  output logic              pwroff_o
);
  logic [BYTE_W-1:0] cfg_q;
  logic pf_stat_q, off_bit_q, pwroff_q, pf_seen_q;
  logic pf_event;

  assign pf_event = (pwr_fail_i != pf_seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      pf_stat_q <= 1'b0;
      off_bit_q <= 1'b0;
      pwroff_q  <= 1'b0;
      pf_seen_q <= 1'b0;
    end else begin
      pf_seen_q <= pwr_fail_i;
      if (cfg_we_i) cfg_q <= wdata_i;
      // input edge wins over a same-cycle clear
      if (pf_event)
        pf_stat_q <= pwr_fail_i && cfg_q[CFG_PF_EN_BIT];
      else if (pwr_we_i && wdata_i[PWR_CLR_BIT])
        pf_stat_q <= 1'b0;
      if (pwr_we_i) begin
        off_bit_q <= wdata_i[PWR_OFF_BIT];
        if (wdata_i[PWR_OFF_BIT]) pwroff_q <= 1'b1;
      end
    end
  end

  always_comb begin
    pwr_reg_o = '0;
    pwr_reg_o[PWR_FAIL_BIT] = pf_stat_q;
    pwr_reg_o[PWR_OFF_BIT]  = off_bit_q;
  end

  assign cfg_o    = cfg_q;
  assign irq_o    = pf_stat_q && cfg_q[CFG_PF_EN_BIT];
  assign pwroff_o = pwroff_q;

  assert_pf_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_event && !cfg_q[CFG_PF_EN_BIT]) |=> !pf_stat_q);
  assert_pf_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_we_i && wdata_i[PWR_CLR_BIT] && !pf_event) |=> !pwr_reg_o[PWR_FAIL_BIT]);
  assert_pwroff_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwroff_o |=> pwroff_o);
endmodule

// File: rtl/aux_pulse.sv
module aux_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= trig_i;
  end

  assert_pulse_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(trig_i));
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_sysctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [4:0]        addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              pwr_fail_i,
  output logic              irq_o,
  output logic              tc_pulse_o,
  output logic              pwroff_o,
  output logic              rst_req_o,
  output logic              halt_o
);
  localparam int unsigned NUM_PULSE = 3;

  logic [NUM_REGS-1:0] wr_hit, rd_hit;
  logic [BYTE_W-1:0]   cfg_v, pwr_v;
  logic [BYTE_W-1:0]   diag_q, mdm_q, aux1_q, sys_q;
  logic [LED_W-1:0]    led_q;
  logic [DATA_W-1:0]   view [NUM_REGS];
  logic [DATA_W-1:0]   rd_mux, rdata_q;
  logic [NUM_PULSE-1:0] trig, pulse;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:LED_W];

  aux_decode u_dec (
    .req_i   (req_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .size_i  (size_i),
    .wr_hit_o(wr_hit),
    .rd_hit_o(rd_hit)
  );

  aux_pwr_unit u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_fail_i(pwr_fail_i),
    .cfg_we_i  (wr_hit[REG_CFG]),
    .pwr_we_i  (wr_hit[REG_PWR]),
    .wdata_i   (wdata_i[BYTE_W-1:0]),
    .cfg_o     (cfg_v),
    .pwr_reg_o (pwr_v),
    .irq_o     (irq_o),
    .pwroff_o  (pwroff_o)
  );

  // registers cleared by reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdm_q  <= '0;
      aux1_q <= '0;
    end else begin
      if (wr_hit[REG_MDM])  mdm_q <= wdata_i[BYTE_W-1:0];
      if (wr_hit[REG_AUX1]) begin
        aux1_q <= wdata_i[BYTE_W-1:0];
        aux1_q[AUX1_TC_BIT] <= 1'b0;
      end
    end
  end

  // registers that survive reset
  always_ff @(posedge clk_i) begin
    if (wr_hit[REG_DIAG]) diag_q <= wdata_i[BYTE_W-1:0];
    if (wr_hit[REG_LED])  led_q  <= wdata_i[LED_W-1:0];
    if (wr_hit[REG_SYS] && wdata_i[SYS_RST_BIT]) sys_q <= SYS_RST_STAT;
  end

  assign trig[0] = wr_hit[REG_AUX1] && wdata_i[AUX1_TC_BIT];
  assign trig[1] = wr_hit[REG_SYS]  && wdata_i[SYS_RST_BIT];
  assign trig[2] = wr_hit[REG_IDLE];

  for (genvar p = 0; p < NUM_PULSE; p++) begin : g_pulse
    aux_pulse u_pulse (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (trig[p]),
      .pulse_o(pulse[p])
    );
  end

  assign tc_pulse_o = pulse[0];
  assign rst_req_o  = pulse[1];
  assign halt_o     = pulse[2];

  always_comb begin
    view[REG_CFG]  = DATA_W'(cfg_v);
    view[REG_DIAG] = DATA_W'(diag_q);
    view[REG_MDM]  = DATA_W'(mdm_q);
    view[REG_LED]  = DATA_W'(led_q);
    view[REG_SYS]  = DATA_W'(sys_q);
    view[REG_AUX1] = DATA_W'(aux1_q);
    view[REG_PWR]  = DATA_W'(pwr_v);
    view[REG_IDLE] = '0;
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_hit[i]) rd_mux = rd_mux | view[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  assert_irq_drop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit[REG_CFG] && !wdata_i[CFG_PF_EN_BIT]) |=> !irq_o);
  assert_aux1_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit[REG_AUX1] |=> !rdata_o[AUX1_TC_BIT]);
  assert_sys_stat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (sys_q == SYS_RST_STAT));
  assert_bad_size_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == SZ_BAD) |=> (rdata_o == '0) && !tc_pulse_o && !halt_o && !rst_req_o);
  assert_idle_rd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wr_i && addr_i == 5'h1C) |=> (rdata_o == '0));
  assert_idle_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !wr_i) |=> (rdata_o == '0));
endmodule

// File: tb/tb_aux_sysctl_regs.sv
module tb_aux_sysctl_regs;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [4:0] addr = '0;
  logic [1:0] size = '0;
  logic [31:0] wdata = '0;
  logic pwr_fail = 1'b0;
  logic [31:0] rdata;
  logic irq, tc, pwroff, rstreq, halt;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  aux_sysctl_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .wr_i(wr), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .pwr_fail_i(pwr_fail),
    .irq_o(irq), .tc_pulse_o(tc), .pwroff_o(pwroff), .rst_req_o(rstreq), .halt_o(halt)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_cfg, m_aux1, m_mdm, m_pwr;
  logic [7:0] m_diag = 'x, m_sys = 'x;
  logic [15:0] m_led = 'x;
  logic m_pf_q, m_off, m_tc, m_rr, m_hl;
  logic [31:0] m_rd;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cfg = 0; m_aux1 = 0; m_mdm = 0; m_pwr = 0; m_pf_q = 0;
      m_off = 0; m_tc = 0; m_rr = 0; m_hl = 0; m_rd = 0;
    end else begin
      int idx;
      bit ok;
      logic [7:0] old_cfg;
      idx = int'(addr[4:2]);
      ok = req && addr[1:0] == 0 &&
           ((idx == 3) ? size == 1 : (idx == 4) ? size == 2 : size == 0);
      old_cfg = m_cfg;
      m_rd = 0; m_tc = 0; m_rr = 0; m_hl = 0;
      if (ok && !wr) begin
        case (idx)
          0: m_rd = {24'd0, m_cfg};
          1: m_rd = {24'd0, m_diag};
          2: m_rd = {24'd0, m_mdm};
          3: m_rd = {16'd0, m_led};
          4: m_rd = {24'd0, m_sys};
          5: m_rd = {24'd0, m_aux1};
          6: m_rd = {24'd0, m_pwr};
          default: m_rd = 0;
        endcase
      end
      if (ok && wr) begin
        case (idx)
          0: m_cfg = wdata[7:0];
          1: m_diag = wdata[7:0];
          2: m_mdm = wdata[7:0];
          3: m_led = wdata[15:0];
          4: if (wdata[0]) begin m_sys = 8'h02; m_rr = 1; end
          5: begin m_aux1 = wdata[7:0] & 8'hFD; m_tc = wdata[1]; end
          6: begin
               m_pwr = {2'b0, (wdata[1] ? 1'b0 : m_pwr[5]), 4'b0, wdata[0]};
               if (wdata[0]) m_off = 1;
             end
          default: m_hl = 1;
        endcase
      end
      if (pwr_fail != m_pf_q) m_pwr[5] = pwr_fail && old_cfg[3];
      m_pf_q = pwr_fail;
    end
  end

  // compared every cycle
  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R1 irq", {31'd0, irq}, {31'd0, m_pwr[5] & m_cfg[3]});
      chk("R5 tc", {31'd0, tc}, {31'd0, m_tc});
      chk("R4 pwroff", {31'd0, pwroff}, {31'd0, m_off});
      chk("R6 rst_req", {31'd0, rstreq}, {31'd0, m_rr});
      chk("R9 halt", {31'd0, halt}, {31'd0, m_hl});
      if (!$isunknown(m_rd)) chk("R10 rdata", rdata, m_rd);
    end
  end

  task automatic acc(bit w, logic [4:0] a, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    req = 1; wr = w; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 0; wr = 0; wdata = 0;
  endtask

  task automatic rd_chk(logic [4:0] a, logic [1:0] s, logic [31:0] exp, string tag);
    acc(0, a, s, 0);
    chk(tag, rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    @(negedge clk); @(negedge clk); rst_ni = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R7 reset rdata", rdata, 0);
    chk("R7 reset pwroff", {31'd0, pwroff}, 0);
    rd_chk(5'h00, 0, 0, "R7 cfg after reset");
    // scratch and LED
    acc(1, 5'h04, 0, 32'hFFFF_FFA5);
    rd_chk(5'h04, 0, 32'hA5, "R11 diag");
    acc(1, 5'h08, 0, 32'h3C);
    rd_chk(5'h08, 0, 32'h3C, "R11 modem");
    acc(1, 5'h0C, 1, 32'h1234_BEEF);
    rd_chk(5'h0C, 1, 32'hBEEF, "R11 led");
    rd_chk(5'h0C, 0, 0, "R8 led byte read");
    acc(1, 5'h0C, 0, 32'h11);
    rd_chk(5'h0C, 1, 32'hBEEF, "R8 led byte write ignored");
    acc(1, 5'h05, 0, 32'h77);
    rd_chk(5'h04, 0, 32'hA5, "R8 misaligned write ignored");
    acc(1, 5'h04, 3, 32'h77);
    rd_chk(5'h04, 0, 32'hA5, "R8 illegal size ignored");
    // power fail
    acc(1, 5'h00, 0, 32'h08);
    rd_chk(5'h00, 0, 32'h08, "R10 cfg readback");
    @(negedge clk); pwr_fail = 1;
    @(negedge clk);
    chk("R1 irq raised", {31'd0, irq}, 1);
    rd_chk(5'h18, 0, 32'h20, "R2 status set");
    acc(1, 5'h00, 0, 32'h00);
    chk("R1 irq gated", {31'd0, irq}, 0);
    rd_chk(5'h18, 0, 32'h20, "R1 status kept while disabled");
    acc(1, 5'h00, 0, 32'h08);
    chk("R1 irq back", {31'd0, irq}, 1);
    acc(1, 5'h18, 0, 32'hFC);
    rd_chk(5'h18, 0, 32'h20, "R3 status preserved");
    acc(1, 5'h18, 0, 32'h02);
    rd_chk(5'h18, 0, 32'h00, "R3 status cleared");
    chk("R3 irq after clear", {31'd0, irq}, 0);
    @(negedge clk); pwr_fail = 0;
    acc(1, 5'h00, 0, 32'h00);
    @(negedge clk); pwr_fail = 1;
    @(negedge clk);
    rd_chk(5'h18, 0, 32'h00, "R2 no status without enable");
    acc(1, 5'h00, 0, 32'h08);
    rd_chk(5'h18, 0, 32'h00, "R2 level alone ignored");
    // terminal count
    acc(1, 5'h14, 0, 32'hFF);
    chk("R5 tc pulse", {31'd0, tc}, 1);
    @(negedge clk);
    chk("R5 tc one cycle", {31'd0, tc}, 0);
    rd_chk(5'h14, 0, 32'hFD, "R5 aux1 readback");
    // system control
    acc(1, 5'h10, 2, 32'hFFFF_FFFE);
    chk("R6 no request without bit0", {31'd0, rstreq}, 0);
    acc(1, 5'h10, 2, 32'h1);
    chk("R6 reset request", {31'd0, rstreq}, 1);
    @(negedge clk);
    chk("R6 request one cycle", {31'd0, rstreq}, 0);
    rd_chk(5'h10, 2, 32'h2, "R6 status readback");
    rd_chk(5'h10, 0, 0, "R8 sysctrl byte read");
    rd_chk(5'h11, 2, 0, "R8 sysctrl offset read");
    // idle
    acc(1, 5'h1C, 0, 32'h0);
    chk("R9 halt", {31'd0, halt}, 1);
    @(negedge clk);
    chk("R9 halt one cycle", {31'd0, halt}, 0);
    rd_chk(5'h1C, 0, 0, "R9 idle read");
    // power off
    acc(1, 5'h18, 0, 32'h01);
    chk("R4 pwroff raised", {31'd0, pwroff}, 1);
    rd_chk(5'h18, 0, 32'h01, "R4 off bit stored");
    acc(1, 5'h18, 0, 32'h00);
    chk("R4 pwroff sticky", {31'd0, pwroff}, 1);
    // selective reset
    acc(1, 5'h14, 0, 32'h41);
    do_reset();
    @(negedge clk);
    chk("R7 pwroff cleared", {31'd0, pwroff}, 0);
    rd_chk(5'h00, 0, 0, "R7 cfg cleared");
    rd_chk(5'h14, 0, 0, "R7 aux1 cleared");
    rd_chk(5'h18, 0, 0, "R7 pwr cleared");
    rd_chk(5'h08, 0, 0, "R7 modem cleared");
    rd_chk(5'h04, 0, 32'hA5, "R7 diag kept");
    rd_chk(5'h0C, 1, 32'hBEEF, "R7 led kept");
    rd_chk(5'h10, 2, 32'h2, "R7 sysctrl kept");
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule